// File: doc/BRIEF.md
# Multi-Chain Mux-Scan State Register

This block holds all of the state flip-flops that sit around an external combinational core. The core reads the present state from the block and returns a next-state word. Every flip-flop is a D cell with a 2:1 selector in front of it. One selector input is the functional next-state bit. The other is a serial bit from the neighbouring cell. A single test-control input picks the same source for every cell in the block.

The cells are grouped into several shift chains. Each chain has its own length, set by a parameter array, so the chains may be unequal. Each chain has its own serial input and serial output. When test control is low, every chain shifts one place per clock. A tester can then load a state into the core and unload the captured response. When test control is high, every cell loads its next-state bit. That is one functional capture.

An optional pin-sharing variant saves package pins. Each chain's last cell drives one of the core's primary output pins while the block is shifting. When the block is in functional mode, that pin carries the core's own output. A synchronous active-high reset clears every cell in either mode. Every cell is clocked from the single clock input.

Top module: `scan_wrap`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, every bit of `present_state` becomes 0 after that edge, whatever the values of `test_ctl`, `scan_in` and `next_state`.
- R2: With `rst` at 0 and `test_ctl` at 1 (capture), `present_state` after the edge equals the `next_state` sampled at that edge, on all chains at once.
- R3: With `rst` at 0 and `test_ctl` at 0 (shift), the first cell of chain k loads `scan_in[k]` at the edge.
- R4: In shift mode, every other cell of a chain loads the value of the cell before it in the same chain. Chains never exchange bits.
- R5: Chain k occupies a contiguous slice of `present_state`. Chain 0 starts at bit 0, and each later chain starts one bit above the end of the previous one. Within a slice, the lowest bit is the cell fed by `scan_in[k]`. `scan_out[k]` always equals the highest bit of slice k. With the default lengths 3, 5 and 4, the slices are [2:0], [7:3] and [11:8].
- R6: With pin sharing enabled and `test_ctl` at 0, `prim_out[k]` equals `scan_out[k]` in the same cycle.
- R7: With `test_ctl` at 1, `prim_out[k]` equals `core_po[k]` in the same cycle.
- R8: A 1 entered on `scan_in[k]`, followed by zeros in shift mode, first appears on `scan_out[k]` after exactly as many shift clocks as chain k has cells. Each chain is counted by its own length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every cell |
| rst | input | 1 | Synchronous active-high clear |
| test_ctl | input | 1 | 0 selects shift, 1 selects functional capture |
| next_state | input | STATE_W | Next-state word from the combinational core |
| present_state | output | STATE_W | Present-state word to the combinational core |
| scan_in | input | NUM_CHAINS | Serial input, one per chain |
| scan_out | output | NUM_CHAINS | Serial output (last cell), one per chain |
| core_po | input | NUM_CHAINS | Core primary-output bits that may share pins with the scan outputs |
| prim_out | output | NUM_CHAINS | Primary output pins (scan output during shift when shared) |

## Verification
Random streams mix capture cycles, shift cycles and occasional resets. Random next-state words show whether capture takes every bit. Random serial inputs show whether shift follows the chain order and keeps the chains apart. Reset is applied in both modes, with ones on all inputs, to show that the clear wins. A directed walk of a single 1 down every chain at the same time tells the unequal lengths apart: it shows whether each chain's output appears after its own count and not after a shared one. The shared output pins are compared against the core's bits in capture and against the chain outputs in shift. This shows whether the selector is steered by test control.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;

    // Test control value 0 shifts, value 1 captures functional data.
    typedef enum logic {
        MODE_SHIFT   = 1'b0,
        MODE_CAPTURE = 1'b1
    } scan_mode_e;

    // The two candidate sources of one scan cell.
    typedef struct packed {
        logic func_d;
        logic ser_d;
    } cell_src_t;

    function automatic scan_mode_e decode_mode(input logic tc);
        return tc ? MODE_CAPTURE : MODE_SHIFT;
    endfunction

    function automatic logic cell_pick(input cell_src_t src, input scan_mode_e mode);
        return (mode == MODE_CAPTURE) ? src.func_d : src.ser_d;
    endfunction

endpackage

// File: rtl/scan_cell.sv
`timescale 1ns/1ps
module scan_cell
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  scan_mode_e mode,
    input  cell_src_t  src,
    output logic       q
);

    logic d_sel;

    always_comb begin
        d_sel = cell_pick(src, mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= d_sel;
        end
    end

endmodule

// File: rtl/scan_chain.sv
`timescale 1ns/1ps
module scan_chain
    import scan_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  scan_mode_e     mode,
    input  logic           si,
    input  logic [LEN-1:0] func_d,
    output logic [LEN-1:0] q,
    output logic           so
);

    for (genvar j = 0; j < LEN; j++) begin : g_cell
        cell_src_t src;
        if (j == 0) begin : g_head
            assign src = '{func_d: func_d[j], ser_d: si};
        end else begin : g_body
            assign src = '{func_d: func_d[j], ser_d: q[j-1]};
        end
        scan_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .src  (src),
            .q    (q[j])
        );
    end

    assign so = q[LEN-1];

endmodule

// File: rtl/scan_po_mux.sv
`timescale 1ns/1ps
module scan_po_mux
    import scan_pkg::*;
#(
    parameter int N     = 3,
    parameter bit SHARE = 1'b1
) (
    input  scan_mode_e   mode,
    input  logic [N-1:0] chain_last,
    input  logic [N-1:0] core_po,
    output logic [N-1:0] prim_out
);

    if (SHARE) begin : g_shared
        always_comb begin
            prim_out = (mode == MODE_SHIFT) ? chain_last : core_po;
        end
    end else begin : g_direct
        assign prim_out = core_po;
    end

endmodule

// File: rtl/scan_wrap.sv
`timescale 1ns/1ps
module scan_wrap
    import scan_pkg::*;
#(
    parameter int NUM_CHAINS            = 3,
    parameter int CHAIN_LEN[NUM_CHAINS] = '{3, 5, 4},
    parameter int STATE_W               = 12,
    parameter bit SHARE_SO              = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  test_ctl,
    input  logic [STATE_W-1:0]    next_state,
    output logic [STATE_W-1:0]    present_state,
    input  logic [NUM_CHAINS-1:0] scan_in,
    output logic [NUM_CHAINS-1:0] scan_out,
    input  logic [NUM_CHAINS-1:0] core_po,
    output logic [NUM_CHAINS-1:0] prim_out
);

    // Index of the first state bit owned by chain k.
    function automatic int chain_base(input int k);
        int acc = 0;
        for (int i = 0; i < k; i++) acc += CHAIN_LEN[i];
        return acc;
    endfunction

    localparam int TOTAL_LEN = chain_base(NUM_CHAINS);

    if (TOTAL_LEN != STATE_W) begin : g_len_mismatch
        $error("chain lengths do not add up to STATE_W");
    end

    scan_mode_e mode;
    assign mode = decode_mode(test_ctl);

    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
        localparam int BASE = chain_base(k);
        localparam int LEN  = CHAIN_LEN[k];
        scan_chain #(.LEN(LEN)) u_chain (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode),
            .si     (scan_in[k]),
            .func_d (next_state[BASE +: LEN]),
            .q      (present_state[BASE +: LEN]),
            .so     (scan_out[k])
        );
    end

    scan_po_mux #(.N(NUM_CHAINS), .SHARE(SHARE_SO)) u_po_mux (
        .mode       (mode),
        .chain_last (scan_out),
        .core_po    (core_po),
        .prim_out   (prim_out)
    );

endmodule

// File: rtl/scan_wrap_chk.sv
`timescale 1ns/1ps
module scan_wrap_chk #(
    parameter int NUM_CHAINS            = 3,
    parameter int CHAIN_LEN[NUM_CHAINS] = '{3, 5, 4},
    parameter int STATE_W               = 12,
    parameter bit SHARE_SO              = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  test_ctl,
    input logic [STATE_W-1:0]    next_state,
    input logic [STATE_W-1:0]    present_state,
    input logic [NUM_CHAINS-1:0] scan_in,
    input logic [NUM_CHAINS-1:0] scan_out,
    input logic [NUM_CHAINS-1:0] core_po,
    input logic [NUM_CHAINS-1:0] prim_out
);

    function automatic int base_of(input int k);
        int acc = 0;
        for (int i = 0; i < k; i++) acc += CHAIN_LEN[i];
        return acc;
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> present_state == '0);

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        test_ctl |=> present_state == $past(next_state));

    assert_po_core_R7: assert property (@(posedge clk) disable iff (rst)
        test_ctl |-> prim_out == core_po);

    if (SHARE_SO) begin : g_share_chk
        assert_po_scan_R6: assert property (@(posedge clk) disable iff (rst)
            !test_ctl |-> prim_out == scan_out);
    end

    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chk_chain
        localparam int B = base_of(k);
        localparam int L = CHAIN_LEN[k];
        assert_head_load_R3: assert property (@(posedge clk) disable iff (rst)
            !test_ctl |=> present_state[B] == $past(scan_in[k]));
        assert_tail_out_R5: assert property (@(posedge clk) disable iff (rst)
            !test_ctl |=> scan_out[k] == $past(present_state[B+L-1 - ((L > 1) ? 1 : 0)]) || (L == 1));
        for (genvar j = 1; j < L; j++) begin : g_chk_bit
            assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
                !test_ctl |=> present_state[B+j] == $past(present_state[B+j-1]));
        end
    end

endmodule

bind scan_wrap scan_wrap_chk #(
    .NUM_CHAINS (NUM_CHAINS),
    .CHAIN_LEN  (CHAIN_LEN),
    .STATE_W    (STATE_W),
    .SHARE_SO   (SHARE_SO)
) u_chk (.*);

// File: tb/scan_wrap_tb.sv
`timescale 1ns/1ps
module scan_wrap_tb;

    localparam int NC       = 3;
    localparam int LEN[NC]  = '{3, 5, 4};
    localparam int SW       = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          test_ctl;
    logic [SW-1:0] next_state;
    logic [SW-1:0] present_state;
    logic [NC-1:0] scan_in;
    logic [NC-1:0] scan_out;
    logic [NC-1:0] core_po;
    logic [NC-1:0] prim_out;

    int checks = 0;
    int errors = 0;
    logic [SW-1:0] exp_state = '0;

    always #5 clk = ~clk;

    scan_wrap u_dut (
        .clk           (clk),
        .rst           (rst),
        .test_ctl      (test_ctl),
        .next_state    (next_state),
        .present_state (present_state),
        .scan_in       (scan_in),
        .scan_out      (scan_out),
        .core_po       (core_po),
        .prim_out      (prim_out)
    );

    function automatic int base_of(input int k);
        int acc = 0;
        for (int i = 0; i < k; i++) acc += LEN[i];
        return acc;
    endfunction

    function automatic logic [NC-1:0] last_bits(input logic [SW-1:0] s);
        logic [NC-1:0] r;
        for (int k = 0; k < NC; k++) r[k] = s[base_of(k) + LEN[k] - 1];
        return r;
    endfunction

    function automatic logic [SW-1:0] model(input logic [SW-1:0] s, input logic r,
                                            input logic tc, input logic [NC-1:0] si,
                                            input logic [SW-1:0] ns);
        logic [SW-1:0] n;
        if (r) return '0;
        if (tc) return ns;
        n = '0;
        for (int k = 0; k < NC; k++) begin
            for (int j = 0; j < LEN[k]; j++) begin
                n[base_of(k)+j] = (j == 0) ? si[k] : s[base_of(k)+j-1];
            end
        end
        return n;
    endfunction

    task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic t, input logic [NC-1:0] si,
                        input logic [SW-1:0] ns, input logic [NC-1:0] po);
        rst = r; test_ctl = t; scan_in = si; next_state = ns; core_po = po;
        #1;
        if (!r) begin
            if (t) check("R7 prim_out", SW'(prim_out), SW'(po));
            else   check("R6 prim_out", SW'(prim_out), SW'(last_bits(exp_state)));
        end
        @(posedge clk);
        #1;
        exp_state = model(exp_state, r, t, si, ns);
        check(r ? "R1 state" : (t ? "R2 state" : "R3 R4 state"), present_state, exp_state);
        check("R5 scan_out", SW'(scan_out), SW'(last_bits(exp_state)));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int first_seen[NC];
        void'($urandom(32'd2024));
        rst = 1'b1; test_ctl = 1'b0; scan_in = '0; next_state = '0; core_po = '0;

        // R1: reset from unknown state, then reset while shifting/capturing ones
        step(1'b1, 1'b0, '1, '1, '0);
        step(1'b1, 1'b1, '1, '1, '0);
        check("R1 reset capture", present_state, '0);
        step(0, 1, '1, 12'hFFF, 3'b101);
        step(1, 0, '1, '1, '0);
        check("R1 reset shift", present_state, '0);

        // Directed: capture alternating patterns, then shift distinct per-chain data
        step(0, 1, '0, 12'hA5C, 3'b010);
        step(0, 1, '0, 12'h5A3, 3'b101);
        step(0, 0, 3'b001, '1, '1);
        step(0, 0, 3'b110, '1, '0);

        // Random mix of capture, shift and rare reset
        for (int n = 0; n < 600; n++) begin
            step(($urandom % 40) == 0, $urandom % 2, NC'($urandom), SW'($urandom), NC'($urandom));
        end

        // R8: walk a single 1 through every chain at once
        step(1, 0, '0, '0, '0);
        for (int k = 0; k < NC; k++) first_seen[k] = 0;
        for (int c = 1; c <= 7; c++) begin
            step(0, 0, (c == 1) ? '1 : '0, SW'($urandom), '0);
            for (int k = 0; k < NC; k++) begin
                if (scan_out[k] && first_seen[k] == 0) first_seen[k] = c;
            end
        end
        for (int k = 0; k < NC; k++) begin
            check("R8 shift count", SW'(first_seen[k]), SW'(LEN[k]));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule